// File: doc/BRIEF.md
# Cyclic TDM Bus Slot Scheduler

This block is the sequencer of a bus controller. It owns a shared bus and hands it out in fixed, equal time slots to a set of slave units. The master starts every transfer. A periodic frame-sync pulse starts each minor frame. Every minor frame has `SLOTS` slots of `SLOT_CYC` clock cycles each, and `MINORS` minor frames make up one major frame. A double-buffered slot table holds one entry per (minor frame, slot) pair. Ownership is therefore decided when the table is configured, never by arbitration at run time. A spare slot position can go to a different low-rate unit in each minor frame. Positions that must stay locked to the frame start are fixed entries. Reserved positions are kept back as margin for recovery traffic.

For each slot, the block drives a one-hot grant, a one-cycle start strobe, the operation the master performs, and the unit IDs taking part. A slave-to-slave move is relayed by the master. The master first reads from the source unit. When that read completes, it writes to the destination unit in the same slot. A transfer that is still busy when its slot ends raises an overrun pulse. A frame-sync pulse that arrives early, or one that is missing when the frame ends, raises a sync-error pulse.

Top module: `tdm_bus_sched`

## Requirements
- R1: Scheduling starts only on the first `fsync` seen with `run` high. Each later slot lasts exactly `SLOT_CYC` cycles. For a transfer slot, `xfer_start` is high for one cycle, on the first cycle of the slot.
- R2: At most one `gnt` bit is high at any time. For a master-write entry (kind 1) or a master-read entry (kind 2), bit `unit` of `gnt` stays high for the whole slot. `xfer_op` is 1 for write and 2 for read, and `src_id` carries the unit.
- R3: A slot's entry is read at table address `minor*SLOTS + slot`. The minor-frame index advances by one at each frame start and wraps to 0 after `MINORS-1`, so one slot position can serve different units in different minor frames.
- R4: An idle entry (kind 0) drives no grant, no start and `xfer_op` 0.
- R5: A reserved entry (kind 4) holds `rsv_slot` high for the whole slot, with no grant and no start.
- R6: A relay entry (kind 3) first grants `unit` with `xfer_op` 2 (read) and a start strobe. On the cycle after `xfer_done` it strobes `xfer_start` again and grants `dst` with `xfer_op` 1 (write). `dst_id` carries `dst`.
- R7: If a started transfer, including the second half of a relay, has not seen `xfer_done` by the last cycle of its slot, `slot_ovr` pulses for one cycle on the first cycle of the next slot.
- R8: An `fsync` that does not fall on the last cycle of a minor frame raises `sync_err` for one cycle and restarts the frame at slot 0 with the next minor index. If a frame ends without `fsync`, `sync_err` pulses and the schedule wraps on its own to slot 0 of the next minor frame.
- R9: Table writes (`tbl_wdata` = {dst, kind[2:0], unit}, with unit in the low bits) go to a shadow copy. A `tbl_commit` takes effect at the next major-frame start. When scheduling is inactive, it takes effect at once.
- R10: While `run` is low, from the next cycle onward there is no grant, no start, no reserved flag and no sync error, and the slot and minor indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Scheduler enable |
| fsync | input | 1 | Periodic frame-sync pulse |
| tbl_we | input | 1 | Shadow table write enable |
| tbl_addr | input | AW | Shadow table address (minor*SLOTS+slot) |
| tbl_wdata | input | EW | Entry {dst, kind, unit} |
| tbl_commit | input | 1 | Request shadow/active swap |
| xfer_done | input | 1 | Current transfer finished |
| gnt | output | UNITS | One-hot bus grant |
| xfer_start | output | 1 | One-cycle transfer start strobe |
| xfer_op | output | 2 | 0 none, 1 write, 2 read |
| xfer_kind | output | 3 | Kind of the current entry |
| src_id | output | IDW | Entry unit (transfer slots), else 0 |
| dst_id | output | IDW | Relay destination, else 0 |
| rsv_slot | output | 1 | Current slot is reserved |
| slot_ovr | output | 1 | Slot overrun pulse |
| sync_err | output | 1 | Frame-sync error pulse |
| cur_slot | output | SW | Current slot index |
| cur_minor | output | MW | Current minor-frame index |

## Verification
The bench builds the block with 4 units, 4 slots of 4 cycles and 3 minor frames. A whole major frame is therefore 48 cycles, and every slot and minor frame can be compared against a model cycle by cycle. Spreading one spare slot over three minor frames (write, relay, idle) exercises rotation and both relay phases. It also lets a table committed in minor frame 1 be seen still unused in minor frame 2 and in use in minor frame 0. Short frames also make early and missing sync pulses, and a dropped done, cheap to place at chosen slot positions.

// File: rtl/tdm_sched_pkg.sv
package tdm_sched_pkg;

  typedef enum logic [2:0] {
    K_IDLE  = 3'd0,
    K_WRITE = 3'd1,
    K_READ  = 3'd2,
    K_RELAY = 3'd3,
    K_RSV   = 3'd4
  } kind_e;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_WR   = 2'd1,
    OP_RD   = 2'd2
  } op_e;

endpackage

// File: rtl/tdm_slot_timer.sv
module tdm_slot_timer #(
  parameter int SLOT_CYC = 8,
  parameter int SLOTS    = 8,
  parameter int MINORS   = 4,
  localparam int CW = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int SW = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int MW = (MINORS > 1) ? $clog2(MINORS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          fsync,
  output logic          active,
  output logic [CW-1:0] cyc,
  output logic [SW-1:0] slot,
  output logic [MW-1:0] minor,
  output logic          slot_first,
  output logic          slot_last,
  output logic          major_edge,
  output logic          sync_err
);

  logic          active_n, err_n;
  logic [CW-1:0] cyc_n;
  logic [SW-1:0] slot_n;
  logic [MW-1:0] minor_n, minor_inc, minor_nx;
  logic          at_cyc_end, frame_end, new_frame;

  always_comb begin
    at_cyc_end = (cyc == CW'(SLOT_CYC - 1));
    frame_end  = active && at_cyc_end && (slot == SW'(SLOTS - 1));
    new_frame  = run && (fsync || frame_end);
    minor_inc  = (minor == MW'(MINORS - 1)) ? '0 : minor + 1'b1;
    minor_nx   = active ? minor_inc : '0;
    major_edge = new_frame && (minor_nx == '0);
    slot_first = active && (cyc == '0);
    slot_last  = active && at_cyc_end;

    active_n = active;
    cyc_n    = cyc;
    slot_n   = slot;
    minor_n  = minor;
    err_n    = 1'b0;
    if (!run) begin
      active_n = 1'b0;
      cyc_n    = '0;
      slot_n   = '0;
      minor_n  = '0;
    end else if (new_frame) begin
      active_n = 1'b1;
      cyc_n    = '0;
      slot_n   = '0;
      minor_n  = minor_nx;
      err_n    = active && (fsync != frame_end);
    end else if (active) begin
      if (at_cyc_end) begin
        cyc_n  = '0;
        slot_n = slot + 1'b1;
      end else begin
        cyc_n  = cyc + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cyc      <= '0;
      slot     <= '0;
      minor    <= '0;
      sync_err <= 1'b0;
    end else begin
      active   <= active_n;
      cyc      <= cyc_n;
      slot     <= slot_n;
      minor    <= minor_n;
      sync_err <= err_n;
    end
  end

  AST_SYNC_ERR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> (cyc == '0 && slot == '0)); // R8

  AST_MINOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    minor <= MW'(MINORS - 1)); // R3

endmodule

// File: rtl/tdm_slot_table.sv
module tdm_slot_table #(
  parameter int DEPTH = 32,
  parameter int EW    = 7,
  parameter int AW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic          commit,
  input  logic          swap_ok,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);

  logic                 act_sel, act_sel_n;
  logic                 pend, pend_n;
  logic [1:0][EW-1:0]   bank_rd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [EW-1:0] mem [DEPTH];
    logic          bank_we;

    assign bank_we    = we && (act_sel != 1'(b)) && (int'(waddr) < DEPTH);
    assign bank_rd[b] = (int'(raddr) < DEPTH) ? mem[raddr] : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (bank_we) begin
        mem[waddr] <= wdata;
      end
    end
  end

  always_comb begin
    pend_n    = pend || commit;
    act_sel_n = act_sel;
    if (pend_n && swap_ok) begin
      act_sel_n = ~act_sel;
      pend_n    = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_sel <= 1'b0;
      pend    <= 1'b0;
    end else begin
      act_sel <= act_sel_n;
      pend    <= pend_n;
    end
  end

  assign rdata = bank_rd[act_sel];

  AST_SWAP_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (act_sel != $past(act_sel)) |-> $past(swap_ok)); // R9

endmodule

// File: rtl/tdm_xfer_seq.sv
module tdm_xfer_seq
  import tdm_sched_pkg::*;
#(
  parameter int UNITS = 4,
  parameter int IDW   = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             active,
  input  logic             slot_first,
  input  logic             slot_last,
  input  kind_e            kind,
  input  logic [IDW-1:0]   unit,
  input  logic [IDW-1:0]   dst,
  input  logic             xfer_done,
  output logic [UNITS-1:0] gnt,
  output logic             start,
  output op_e              op,
  output logic [IDW-1:0]   src_id,
  output logic [IDW-1:0]   dst_id,
  output logic             rsv,
  output logic             ovr
);

  logic           busy, busy_n;
  logic           ph2, ph2_n;
  logic           st2, st2_n;
  logic           ovr_n;
  logic           is_xfer, is_relay;
  logic [IDW-1:0] sel_id;

  always_comb begin
    is_xfer  = (kind == K_WRITE) || (kind == K_READ) || (kind == K_RELAY);
    is_relay = (kind == K_RELAY);

    busy_n = busy;
    ph2_n  = ph2;
    st2_n  = 1'b0;
    ovr_n  = 1'b0;
    if (!active) begin
      busy_n = 1'b0;
      ph2_n  = 1'b0;
    end else if (slot_last) begin
      busy_n = 1'b0;
      ph2_n  = 1'b0;
      ovr_n  = busy && !(xfer_done && (!is_relay || ph2));
    end else if (slot_first && is_xfer) begin
      busy_n = 1'b1;
      ph2_n  = 1'b0;
    end else if (busy && xfer_done) begin
      if (is_relay && !ph2) begin
        ph2_n = 1'b1;
        st2_n = 1'b1;
      end else begin
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      ph2  <= 1'b0;
      st2  <= 1'b0;
      ovr  <= 1'b0;
    end else begin
      busy <= busy_n;
      ph2  <= ph2_n;
      st2  <= st2_n;
      ovr  <= ovr_n;
    end
  end

  always_comb begin
    sel_id = ph2 ? dst : unit;
    gnt    = is_xfer ? (UNITS'(1) << sel_id) : '0;
    start  = (slot_first && is_xfer) || st2;
    rsv    = (kind == K_RSV);
    src_id = is_xfer ? unit : '0;
    dst_id = is_relay ? dst : '0;
    case (kind)
      K_WRITE: op = OP_WR;
      K_READ:  op = OP_RD;
      K_RELAY: op = ph2 ? OP_WR : OP_RD;
      default: op = OP_NONE;
    endcase
  end

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !start); // R1

  AST_RELAY_WRITE_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !slot_first) |-> $past(xfer_done)); // R6

endmodule

// File: rtl/tdm_bus_sched.sv
module tdm_bus_sched
  import tdm_sched_pkg::*;
#(
  parameter int UNITS    = 4,
  parameter int SLOT_CYC = 8,
  parameter int SLOTS    = 8,
  parameter int MINORS   = 4,
  localparam int IDW   = (UNITS > 1) ? $clog2(UNITS) : 1,
  localparam int EW    = 2 * IDW + 3,
  localparam int DEPTH = SLOTS * MINORS,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW    = (SLOT_CYC > 1) ? $clog2(SLOT_CYC) : 1,
  localparam int SW    = (SLOTS > 1) ? $clog2(SLOTS) : 1,
  localparam int MW    = (MINORS > 1) ? $clog2(MINORS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             fsync,
  input  logic             tbl_we,
  input  logic [AW-1:0]    tbl_addr,
  input  logic [EW-1:0]    tbl_wdata,
  input  logic             tbl_commit,
  input  logic             xfer_done,
  output logic [UNITS-1:0] gnt,
  output logic             xfer_start,
  output logic [1:0]       xfer_op,
  output logic [2:0]       xfer_kind,
  output logic [IDW-1:0]   src_id,
  output logic [IDW-1:0]   dst_id,
  output logic             rsv_slot,
  output logic             slot_ovr,
  output logic             sync_err,
  output logic [SW-1:0]    cur_slot,
  output logic [MW-1:0]    cur_minor
);

  logic          tm_active, tm_first, tm_last, tm_major;
  logic [CW-1:0] tm_cyc;
  logic [AW-1:0] tbl_raddr;
  logic [EW-1:0] tbl_rdata;
  kind_e         ent_kind, kind_cur;
  op_e           seq_op;

  tdm_slot_timer #(
    .SLOT_CYC (SLOT_CYC),
    .SLOTS    (SLOTS),
    .MINORS   (MINORS)
  ) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .fsync      (fsync),
    .active     (tm_active),
    .cyc        (tm_cyc),
    .slot       (cur_slot),
    .minor      (cur_minor),
    .slot_first (tm_first),
    .slot_last  (tm_last),
    .major_edge (tm_major),
    .sync_err   (sync_err)
  );

  assign tbl_raddr = AW'(cur_minor) * AW'(SLOTS) + AW'(cur_slot);

  tdm_slot_table #(
    .DEPTH (DEPTH),
    .EW    (EW),
    .AW    (AW)
  ) table_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (tbl_we),
    .waddr   (tbl_addr),
    .wdata   (tbl_wdata),
    .commit  (tbl_commit),
    .swap_ok (!tm_active || tm_major),
    .raddr   (tbl_raddr),
    .rdata   (tbl_rdata)
  );

  assign ent_kind = kind_e'(tbl_rdata[IDW+2:IDW]);
  assign kind_cur = tm_active ? ent_kind : K_IDLE;

  tdm_xfer_seq #(
    .UNITS (UNITS),
    .IDW   (IDW)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .active     (tm_active),
    .slot_first (tm_first),
    .slot_last  (tm_last),
    .kind       (kind_cur),
    .unit       (tbl_rdata[IDW-1:0]),
    .dst        (tbl_rdata[EW-1:IDW+3]),
    .xfer_done  (xfer_done),
    .gnt        (gnt),
    .start      (xfer_start),
    .op         (seq_op),
    .src_id     (src_id),
    .dst_id     (dst_id),
    .rsv        (rsv_slot),
    .ovr        (slot_ovr)
  );

  assign xfer_op   = seq_op;
  assign xfer_kind = kind_cur;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt)); // R2

  AST_START_GRANTED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (gnt != '0)); // R1

  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (gnt == '0 && !xfer_start && !rsv_slot)); // R10

  AST_OVR_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    slot_ovr |-> (tm_cyc == '0)); // R7

  AST_RSV_NO_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    rsv_slot |-> (gnt == '0 && !xfer_start)); // R5

endmodule

// File: tb/tdm_bus_sched_tb.sv
module tdm_bus_sched_tb_top;

  logic       clk, rst_n, run, fsync, tbl_we, tbl_commit, xfer_done;
  logic [3:0] tbl_addr;
  logic [6:0] tbl_wdata;
  logic [3:0] gnt;
  logic       xfer_start, rsv_slot, slot_ovr, sync_err;
  logic [1:0] xfer_op, src_id, dst_id, cur_slot, cur_minor;
  logic [2:0] xfer_kind;

  int checks = 0;
  int errors = 0;
  int mk[3][4], mu[3][4], md[3][4];
  int nk[3][4], nu[3][4], nd[3][4];

  tdm_bus_sched #(.UNITS(4), .SLOT_CYC(4), .SLOTS(4), .MINORS(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .fsync(fsync),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .tbl_commit(tbl_commit), .xfer_done(xfer_done),
    .gnt(gnt), .xfer_start(xfer_start), .xfer_op(xfer_op), .xfer_kind(xfer_kind),
    .src_id(src_id), .dst_id(dst_id), .rsv_slot(rsv_slot), .slot_ovr(slot_ovr),
    .sync_err(sync_err), .cur_slot(cur_slot), .cur_minor(cur_minor)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [6:0] enc(input int k, input int u, input int d);
    return {2'(d), 3'(k), 2'(u)};
  endfunction

  task automatic step(input logic fs, input logic dn);
    fsync = fs;
    xfer_done = dn;
    @(posedge clk);
    #1;
    fsync = 1'b0;
    xfer_done = 1'b0;
    tbl_we = 1'b0;
    tbl_commit = 1'b0;
  endtask

  // Table A: slot0 write u1, slot1 read u2, slot2 rotates, slot3 reserved
  task automatic set_tables();
    for (int m = 0; m < 3; m++) begin
      mk[m][0] = 1; mu[m][0] = 1; md[m][0] = 0;
      mk[m][1] = 2; mu[m][1] = 2; md[m][1] = 0;
      mk[m][3] = 4; mu[m][3] = 0; md[m][3] = 0;
      nk[m][0] = 2; nu[m][0] = 3; nd[m][0] = 0;
      nk[m][1] = 1; nu[m][1] = 0; nd[m][1] = 0;
      nk[m][2] = 4; nu[m][2] = 0; nd[m][2] = 0;
      nk[m][3] = 0; nu[m][3] = 0; nd[m][3] = 0;
    end
    mk[0][2] = 1; mu[0][2] = 3; md[0][2] = 0;
    mk[1][2] = 3; mu[1][2] = 1; md[1][2] = 3;
    mk[2][2] = 0; mu[2][2] = 0; md[2][2] = 0;
  endtask

  task automatic use_new_table();
    for (int m = 0; m < 3; m++)
      for (int s = 0; s < 4; s++) begin
        mk[m][s] = nk[m][s]; mu[m][s] = nu[m][s]; md[m][s] = nd[m][s];
      end
  endtask

  // One minor frame, checked cycle by cycle against the table model
  task automatic play_frame(input int m, input int drop, input bit sync_end, input bit wr_new);
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c < 4; c++) begin
        int k, i, eg, es, eo, er, eovr;
        string tg;
        bit dn;
        k = mk[m][s];
        i = s * 4 + c;
        eg = 0; es = 0; eo = 0; er = 0;
        tg = (k == 0) ? "R4" : (k == 4) ? "R5" : (k == 3) ? "R6" : "R2";
        case (k)
          1: begin eg = 1 << mu[m][s]; es = (c == 0); eo = 1; end
          2: begin eg = 1 << mu[m][s]; es = (c == 0); eo = 2; end
          3: begin eg = 1 << ((c >= 2) ? md[m][s] : mu[m][s]);
                   es = (c == 0 || c == 2); eo = (c >= 2) ? 1 : 2; end
          4: er = 1;
          default: ;
        endcase
        eovr = (drop >= 0 && s == drop + 1 && c == 0) ? 1 : 0;
        chk({tg, " gnt"}, int'(gnt), eg);
        chk("R1 start", int'(xfer_start), es);
        chk({tg, " op"}, int'(xfer_op), eo);
        chk({tg, " rsv"}, int'(rsv_slot), er);
        chk("R7 ovr", int'(slot_ovr), eovr);
        chk("R1 slot", int'(cur_slot), s);
        chk("R3 minor", int'(cur_minor), m);
        if (k == 3) chk("R6 dst_id", int'(dst_id), md[m][s]);
        if (i != 0) chk("R8 no sync_err", int'(sync_err), 0);
        dn = (k >= 1 && k <= 3) && (s != drop) && (c == 1 || (k == 3 && c == 3));
        if (wr_new) begin
          if (i < 12) begin
            tbl_we = 1'b1;
            tbl_addr = 4'(i);
            tbl_wdata = enc(nk[i / 4][i % 4], nu[i / 4][i % 4], nd[i / 4][i % 4]);
          end else if (i == 12) begin
            tbl_commit = 1'b1;
          end
        end
        step(sync_end && s == 3 && c == 3, dn);
      end
    end
  endtask

  task automatic test_reset();
    chk("R10 reset gnt", int'(gnt), 0);
    chk("R10 reset start", int'(xfer_start), 0);
    chk("R10 reset ovr", int'(slot_ovr), 0);
    chk("R10 reset sync_err", int'(sync_err), 0);
    chk("R10 reset slot", int'(cur_slot), 0);
  endtask

  task automatic test_load_and_rotate();
    for (int i = 0; i < 12; i++) begin
      tbl_we = 1'b1;
      tbl_addr = 4'(i);
      tbl_wdata = enc(mk[i / 4][i % 4], mu[i / 4][i % 4], md[i / 4][i % 4]);
      step(1'b0, 1'b0);
    end
    tbl_commit = 1'b1;
    step(1'b0, 1'b0);   // R9: inactive, swap at once
    run = 1'b1;
    for (int i = 0; i < 5; i++) begin
      step(1'b0, 1'b0);
      chk("R1 wait for sync", int'(gnt), 0);
    end
    step(1'b1, 1'b0);
    chk("R8 first sync no error", int'(sync_err), 0);
    play_frame(0, -1, 1'b1, 1'b0);
    play_frame(1, -1, 1'b1, 1'b0);
    play_frame(2, -1, 1'b1, 1'b0);
    play_frame(0, -1, 1'b1, 1'b0);
  endtask

  task automatic test_overrun_and_swap();
    play_frame(1, 0, 1'b1, 1'b1);   // R7 drop done in slot 0, R9 write shadow
    play_frame(2, -1, 1'b1, 1'b0);  // R9 old table still in use
    use_new_table();
    play_frame(0, -1, 1'b1, 1'b0);  // R9 new table from major start
  endtask

  task automatic test_sync_errors();
    for (int i = 0; i < 6; i++) step(1'b0, i == 1);
    step(1'b1, 1'b0);               // early sync at slot1 cyc2
    chk("R8 early sync_err", int'(sync_err), 1);
    chk("R8 early slot", int'(cur_slot), 0);
    chk("R8 early minor", int'(cur_minor), 2);
    play_frame(2, -1, 1'b0, 1'b0);  // frame ends with no sync
    chk("R8 late sync_err", int'(sync_err), 1);
    chk("R8 late wrap slot", int'(cur_slot), 0);
    chk("R8 late wrap minor", int'(cur_minor), 0);
    play_frame(0, -1, 1'b1, 1'b0);
  endtask

  task automatic test_stop();
    run = 1'b0;
    step(1'b0, 1'b0);
    chk("R10 stop gnt", int'(gnt), 0);
    chk("R10 stop start", int'(xfer_start), 0);
    chk("R10 stop slot", int'(cur_slot), 0);
    chk("R10 stop minor", int'(cur_minor), 0);
    step(1'b1, 1'b0);
    chk("R10 stop no sync_err", int'(sync_err), 0);
    chk("R10 stop rsv", int'(rsv_slot), 0);
    run = 1'b1;
    step(1'b1, 1'b0);
    play_frame(0, -1, 1'b1, 1'b0);  // R1 restart repeats same sequence
  endtask

  initial begin
    rst_n = 1'b0; run = 1'b0; fsync = 1'b0; xfer_done = 1'b0;
    tbl_we = 1'b0; tbl_commit = 1'b0; tbl_addr = '0; tbl_wdata = '0;
    set_tables();
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    step(1'b0, 1'b0);
    test_reset();
    test_load_and_rotate();
    test_overrun_and_swap();
    test_sync_errors();
    test_stop();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule